// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a clocked, byte-writable static memory with a registered read path and a built-in four-beat burst address generator. It has a 32-bit word and a depth set by a parameter. Every control and address input is captured on the rising clock edge. The one exception is the output enable, which acts on the data drive enable at once. The data bus is split into a write-data input, a read-data output and a drive-enable output, so the pad ring can build the tri-state driver from them.

A cycle that strobes the address with the chip enabled loads an external address and starts a burst. The cycle reads or writes depending on the byte-write gate and the lane enables. Later cycles with the strobe released continue the burst. With the step input low they move to the next beat. With it high they repeat the current address as a wait cycle. A static order input picks the beat order:
- Linear order adds the beat count to the low two address bits, wrapping within the four-word block.
- Interleaved order XORs the beat count into the low two address bits.

A standby input freezes the block. It keeps the contents and the burst position, and it accepts no cycles.

The block has no valid/ready handshake. Every captured cycle completes in one clock, and read data follows one clock later, so there is no back-pressure.

Top module: `pburst_sram`

## Requirements
- R1: After reset, `data_oe` is low. Continue cycles (`adstb_n` high) access nothing until a burst has been loaded.
- R2: A load cycle that reads word A (`adstb_n`=0, `cen_n`=0, `sleep`=0, read by R4) presents word A on `data_o` after that edge. `data_oe` is high in that following cycle while `oen_n` is low.
- R3: On a write, lane enable `lane_n[k]`=0 writes bits 8k+7:8k of `data_i` into the addressed word. The lanes whose enable is 1 keep their old bits.
- R4: A cycle writes only when `wgate_n` is 0 and at least one bit of `lane_n` is 0. Every other cycle is a read.
- R5: With `order_sel`=0, beat k of a burst loaded at address B accesses the address whose upper bits equal those of B and whose low two bits are (B+k) mod 4. Each continue cycle with `step_n`=0 advances k by one.
- R6: With `order_sel`=1, beat k accesses the address whose upper bits equal those of B and whose low two bits are B[1:0] XOR k.
- R7: A continue cycle with `step_n`=1 accesses the same address as the previous access. `cen_n` has no effect on any continue cycle.
- R8: A deselect cycle (`adstb_n`=0, `cen_n`=1) drives `data_oe` low after the edge. Continue cycles after it access nothing until the next load.
- R9: `oen_n` gates `data_oe` without waiting for a clock edge.
- R10: After a write cycle, `data_oe` is low.
- R11: While `sleep` is 1, no cycle is accepted, memory contents and the burst position are kept, and `data_oe` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr_in | input | ADDR_W | External word address, used on load cycles |
| cen_n | input | 1 | Active-low chip enable, used when `adstb_n` is low |
| adstb_n | input | 1 | Active-low address strobe: load or deselect when low, continue when high |
| lane_n | input | 4 | Active-low byte-lane enables, bit k for bits 8k+7:8k |
| wgate_n | input | 1 | Active-low byte-write gate |
| step_n | input | 1 | Active-low burst advance on continue cycles; high means hold |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Active-high standby |
| oen_n | input | 1 | Active-low asynchronous output enable |
| data_i | input | 32 | Write data, captured with the cycle |
| data_o | output | 32 | Registered read data |
| data_oe | output | 1 | Drive enable for the bidirectional data pad |

## Verification
The bench builds the block with `ADDR_W`=4, a 16-word array, so a reference model can track every word. It loads bursts in both orders from every one of the 16 start addresses, which covers each low-address offset and each upper block. With the small array the bench can also apply all 16 lane-enable patterns to one word, and it can inject holds, chip-enable noise on continue cycles, deselects and standby inside live bursts.

// File: rtl/pbs_pkg.sv
`timescale 1ns/1ps
package pbs_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_LOAD = 2'd1,
    CYC_NEXT = 2'd2,
    CYC_DROP = 2'd3
  } cyc_e;

  // low address bits for a given beat count
  function automatic logic [BURST_W-1:0] beat_lsb(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               interleave
  );
    return interleave ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/pbs_decode.sv
`timescale 1ns/1ps
module pbs_decode #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep,
  input  logic                 adstb_n,
  input  logic                 cen_n,
  input  logic                 wgate_n,
  input  logic [LANES-1:0]     lane_n,
  output pbs_pkg::cyc_e        kind,
  output logic                 live,
  output logic                 acc_en,
  output logic                 rd_en,
  output logic                 wr_en,
  output logic [LANES-1:0]     lane_we
);
  import pbs_pkg::*;

  logic live_q;
  logic is_write;

  always_comb begin
    if (sleep)         kind = CYC_NONE;
    else if (!adstb_n) kind = cen_n ? CYC_DROP : CYC_LOAD;
    else if (live_q)   kind = CYC_NEXT;
    else               kind = CYC_NONE;
  end

  assign is_write = !wgate_n && (lane_n != {LANES{1'b1}});
  assign acc_en   = (kind == CYC_LOAD) || (kind == CYC_NEXT);
  assign wr_en    = acc_en && is_write;
  assign rd_en    = acc_en && !is_write;
  assign lane_we  = wr_en ? ~lane_n : '0;
  assign live     = live_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 live_q <= 1'b0;
    else if (kind == CYC_LOAD)  live_q <= 1'b1;
    else if (kind == CYC_DROP)  live_q <= 1'b0;
  end
endmodule

// File: rtl/pbs_burst.sv
`timescale 1ns/1ps
module pbs_burst #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pbs_pkg::cyc_e     kind,
  input  logic              step_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr
);
  import pbs_pkg::*;

  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_nxt;

  always_comb begin
    beat_nxt = beat_q;
    if (kind == CYC_NEXT && !step_n) beat_nxt = beat_q + 1'b1;
    if (kind == CYC_LOAD) acc_addr = addr_in;
    else acc_addr = {base_q[ADDR_W-1:BURST_W],
                     beat_lsb(base_q[BURST_W-1:0], beat_nxt, interleave)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (kind == CYC_LOAD) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (kind == CYC_NEXT) begin
      beat_q <= beat_nxt;
    end
  end
endmodule

// File: rtl/pbs_array.sv
`timescale 1ns/1ps
module pbs_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd_en,
  input  logic [LANES-1:0]          lane_we,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rd_valid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (lane_we[k]) mem[addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
    end
    if (rd_en) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end
endmodule

// File: rtl/pburst_sram.sv
`timescale 1ns/1ps
module pburst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     cen_n,
  input  logic                     adstb_n,
  input  logic [LANES-1:0]         lane_n,
  input  logic                     wgate_n,
  input  logic                     step_n,
  input  logic                     order_sel,
  input  logic                     sleep,
  input  logic                     oen_n,
  input  logic [LANES*LANE_W-1:0]  data_i,
  output logic [LANES*LANE_W-1:0]  data_o,
  output logic                     data_oe
);
  import pbs_pkg::*;

  cyc_e              kind;
  logic              live;
  logic              acc_en;
  logic              rd_en;
  logic              wr_en;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] acc_addr;
  logic              rd_valid;

  pbs_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .adstb_n(adstb_n), .cen_n(cen_n),
    .wgate_n(wgate_n), .lane_n(lane_n), .kind(kind), .live(live),
    .acc_en(acc_en), .rd_en(rd_en), .wr_en(wr_en), .lane_we(lane_we)
  );

  pbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .kind(kind), .step_n(step_n),
    .interleave(order_sel), .addr_in(addr_in), .acc_addr(acc_addr)
  );

  pbs_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(acc_addr), .rd_en(rd_en),
    .lane_we(lane_we), .wdata(data_i), .rdata(data_o), .rd_valid(rd_valid)
  );

  // output enable acts without a clock edge
  assign data_oe = rd_valid && !oen_n;
endmodule

// File: rtl/pbs_checker.sv
`timescale 1ns/1ps
module pbs_checker #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              adstb_n,
  input logic              cen_n,
  input logic              wgate_n,
  input logic [LANES-1:0]  lane_n,
  input logic              step_n,
  input logic              oen_n,
  input logic              data_oe,
  input logic              acc_en,
  input logic [ADDR_W-1:0] acc_addr
);
  logic              prev_acc;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_acc  <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_acc  <= acc_en;
      prev_addr <= acc_addr;
    end
  end

  // R8
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adstb_n && cen_n) |=> !data_oe);

  // R10
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adstb_n && !cen_n && !wgate_n && lane_n != {LANES{1'b1}}) |=> !data_oe);

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !data_oe);

  // R2
  read_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adstb_n && !cen_n && (wgate_n || lane_n == {LANES{1'b1}}))
      |=> (data_oe == !oen_n));

  // R7
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && adstb_n && step_n && acc_en && prev_acc) |-> (acc_addr == prev_addr));

  // R5 R6
  step_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && adstb_n && !step_n && acc_en && prev_acc)
      |-> (acc_addr[ADDR_W-1:2] == prev_addr[ADDR_W-1:2]));
endmodule

bind pburst_sram pbs_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pbs_checker (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .adstb_n(adstb_n), .cen_n(cen_n),
  .wgate_n(wgate_n), .lane_n(lane_n), .step_n(step_n), .oen_n(oen_n),
  .data_oe(data_oe), .acc_en(acc_en), .acc_addr(acc_addr)
);

// File: tb/test_pburst_sram.sv
`timescale 1ns/1ps
module test_pburst_sram;
  localparam int AW = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          cen_n, adstb_n, wgate_n, step_n, order_sel, sleep, oen_n;
  logic [3:0]    lane_n;
  logic [31:0]   data_i;
  logic [31:0]   data_o;
  logic          data_oe;

  logic [31:0]   ref_mem [WORDS];
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pburst_sram #(.ADDR_W(AW)) i_pburst_sram (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .cen_n(cen_n), .adstb_n(adstb_n),
    .lane_n(lane_n), .wgate_n(wgate_n), .step_n(step_n), .order_sel(order_sel),
    .sleep(sleep), .oen_n(oen_n), .data_i(data_i), .data_o(data_o), .data_oe(data_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // inputs are applied at a falling edge; returns at the falling edge after the capture
  task automatic cyc(input logic a_n, input logic c_n, input logic w_n, input logic [3:0] l_n,
                     input logic s_n, input logic [AW-1:0] ad, input logic [31:0] wd);
    adstb_n = a_n; cen_n = c_n; wgate_n = w_n; lane_n = l_n;
    step_n = s_n; addr_in = ad; data_i = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_expect(input string req, input logic [AW-1:0] a);
    chk(req, {31'b0, data_oe}, 32'd1);
    chk(req, data_o, ref_mem[a]);
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int k, input logic il);
    logic [AW-1:0] r;
    logic [1:0]    kk;
    kk = k[1:0];
    r = b;
    r[1:0] = il ? (b[1:0] ^ kk) : (b[1:0] + kk);
    return r;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] l_n);
    logic [31:0] r;
    r = old;
    for (int k = 0; k < 4; k++) if (!l_n[k]) r[k*8 +: 8] = nw[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] seed(input int a);
    return 32'hA500_0000 ^ (a * 32'h0103_0507);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [31:0]   wd;
    rst_n = 1'b0; sleep = 1'b0; oen_n = 1'b0; order_sel = 1'b0;
    adstb_n = 1'b1; cen_n = 1'b1; wgate_n = 1'b1; lane_n = 4'hF;
    step_n = 1'b1; addr_in = '0; data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {31'b0, data_oe}, 32'd0);
    rst_n = 1'b1;
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    chk("R1 continue before load", {31'b0, data_oe}, 32'd0);

    // fill every word (R10: no drive after writes)
    for (int i = 0; i < WORDS; i++) begin
      cyc(0, 0, 0, 4'h0, 1, i[AW-1:0], seed(i));
      ref_mem[i] = seed(i);
      chk("R10 write no drive", {31'b0, data_oe}, 32'd0);
    end

    // R2 and R4: gate high, or no lane enabled, means read
    cyc(0, 0, 1, 4'h0, 1, 3, 32'hFFFF_FFFF);
    rd_expect("R4 gate high reads", 3);
    cyc(0, 0, 0, 4'hF, 1, 6, 32'hFFFF_FFFF);
    rd_expect("R4 no lanes reads", 6);
    cyc(0, 0, 1, 4'hF, 1, 7, 0);
    rd_expect("R2 plain read", 7);

    // R3: every lane pattern on word 5
    for (int m = 0; m < 16; m++) begin
      wd = 32'h1122_3344 + m * 32'h0101_0101;
      cyc(0, 0, 0, m[3:0], 1, 5, wd);
      if (m != 15) ref_mem[5] = merge(ref_mem[5], wd, m[3:0]);
      cyc(0, 0, 1, 4'hF, 1, 5, 0);
      rd_expect("R3 lane mask", 5);
    end

    // R5 / R6 / R7: bursts from every start in both orders
    for (int mo = 0; mo < 2; mo++) begin
      order_sel = mo[0];
      for (int s = 0; s < WORDS; s++) begin
        cyc(0, 0, 1, 4'hF, 1, s[AW-1:0], 0);
        rd_expect(mo ? "R6 beat0" : "R5 beat0", s[AW-1:0]);
        cyc(1, 1, 1, 4'hF, 0, 0, 0);
        rd_expect(mo ? "R6 beat1" : "R5 beat1", beat_addr(s[AW-1:0], 1, mo[0]));
        cyc(1, 0, 1, 4'hF, 1, 0, 0);
        rd_expect("R7 hold", beat_addr(s[AW-1:0], 1, mo[0]));
        cyc(1, 1, 1, 4'hF, 1, 0, 0);
        rd_expect("R7 hold cen high", beat_addr(s[AW-1:0], 1, mo[0]));
        for (int k = 2; k < 5; k++) begin
          cyc(1, 0, 1, 4'hF, 0, 0, 0);
          rd_expect(mo ? "R6 beat" : "R5 beat", beat_addr(s[AW-1:0], k, mo[0]));
        end
      end
    end

    // burst write in interleaved order, then read back
    order_sel = 1'b1;
    cyc(0, 0, 0, 4'h0, 1, 9, 32'hC0DE_0000);
    ref_mem[9] = 32'hC0DE_0000;
    for (int k = 1; k < 4; k++) begin
      wd = 32'hC0DE_0000 + k;
      cyc(1, 0, 0, 4'h0, 0, 0, wd);
      ref_mem[beat_addr(9, k, 1'b1)] = wd;
      chk("R10 burst write no drive", {31'b0, data_oe}, 32'd0);
    end
    for (int k = 0; k < 4; k++) begin
      a = beat_addr(9, k, 1'b1);
      cyc(0, 0, 1, 4'hF, 1, a, 0);
      rd_expect("R6 burst write landed", a);
    end

    // R9: output enable without a clock edge
    cyc(0, 0, 1, 4'hF, 1, 2, 0);
    #0.5 oen_n = 1'b1;
    #0.5 chk("R9 oe off async", {31'b0, data_oe}, 32'd0);
    oen_n = 1'b0;
    #0.5 chk("R9 oe on async", {31'b0, data_oe}, 32'd1);
    @(negedge clk);

    // R8: deselect ends the burst
    cyc(0, 0, 1, 4'hF, 1, 4, 0);
    cyc(0, 1, 1, 4'hF, 1, 4, 0);
    chk("R8 deselect", {31'b0, data_oe}, 32'd0);
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    chk("R8 no continue after deselect", {31'b0, data_oe}, 32'd0);

    // R11: standby blocks cycles, keeps contents and position
    order_sel = 1'b0;
    cyc(0, 0, 1, 4'hF, 1, 2, 0);
    rd_expect("R11 pre-sleep read", 2);
    sleep = 1'b1;
    cyc(0, 0, 0, 4'h0, 1, 2, 32'hDEAD_BEEF);
    chk("R11 sleep no drive", {31'b0, data_oe}, 32'd0);
    cyc(1, 0, 0, 4'h0, 0, 0, 32'hDEAD_BEEF);
    chk("R11 sleep no drive 2", {31'b0, data_oe}, 32'd0);
    sleep = 1'b0;
    cyc(1, 0, 1, 4'hF, 0, 0, 0);
    rd_expect("R11 position kept", beat_addr(2, 1, 1'b0));
    cyc(0, 0, 1, 4'hF, 1, 2, 0);
    rd_expect("R11 contents kept", 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule